// File: doc/BRIEF.md
# Register File with Constant Generator

This block is the operand store of a small 16-bit RISC core. It holds sixteen 16-bit registers, serves one source operand and one destination operand per cycle through two combinational read ports, and accepts one register write per clock edge. The source port also takes the 2-bit addressing-mode field of the instruction. When the source is entry 2 or entry 3, the mode picks a fixed constant in place of the stored contents. This lets the core encode common small constants such as 0, 1, 2, 4, 8 and all-ones without an extra code word or memory fetch.

Entry 2 is also the status word. Its three low bits hold carry, zero and negative flags, which are updated from ALU results at the active operand size. The next five bits are control bits that software writes, and they drive interrupt-enable, core-halt and clock-control outputs. Both word and byte writes are supported. A byte write keeps the low eight bits of the data and zeroes the upper half.

Top module: `regfile_cg`

## Requirements
- R1: Port B (`rd_b_idx`/`rd_b_data`) returns the stored 16-bit value of the addressed entry in the same cycle. A word write to any entry other than 3 stores all 16 bits of `wr_data`. The new value is visible from the cycle after the write edge, and a read in the write cycle still returns the old value.
- R2: A byte write (`wr_byte`=1) stores `wr_data[7:0]` in bits 7:0 of the target entry and clears bits 15:8.
- R3: With `rd_a_idx`=3, port A returns 0x0000, 0x0001, 0x0002 or 0xFFFF for `rd_a_mode` 0, 1, 2 or 3, in the same cycle. Writes to entry 3 are discarded, so port B always reads entry 3 as 0x0000.
- R4: With `rd_a_idx`=2, port A returns the stored status word for mode 0, 0x0000 for mode 1, 0x0004 for mode 2 and 0x0008 for mode 3.
- R5: For any other index, port A returns the stored contents whatever the mode.
- R6: When `flg_en`=1, the status word takes C (bit 0) = `flg_carry`, Z (bit 1) = result is zero, and N (bit 2) = result sign bit. The result is `flg_result[7:0]` with sign bit 7 when `flg_byte`=1, and the full 16 bits with sign bit 15 otherwise. Bits 15:3 are unchanged.
- R7: The status bits from bit 3 upward are interrupt enable, core off, oscillator off, clock control 0 and clock control 1. `gie_o` = bit 3, `core_off_o` = bit 4, `osc_off_o` = bit 5 and `scg_o` = bits 7:6.
- R8: If a write to entry 2 and a flag update occur in the same cycle, only the write takes effect.
- R9: A synchronous active-high `rst` clears every entry, including the status word, so all outputs derived from state read zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Source operand register index |
| rd_a_mode | input | 2 | Source addressing mode (selects constants on entries 2 and 3) |
| rd_a_data | output | 16 | Source operand value |
| rd_b_idx | input | 4 | Destination operand register index |
| rd_b_data | output | 16 | Stored value of the destination entry |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Write target index |
| wr_byte | input | 1 | 1 = byte write, 0 = word write |
| wr_data | input | 16 | Write data |
| flg_en | input | 1 | Flag update enable |
| flg_byte | input | 1 | Flag operand size: 1 = byte, 0 = word |
| flg_result | input | 16 | ALU result used for Z and N |
| flg_carry | input | 1 | ALU carry out |
| gie_o | output | 1 | Maskable interrupt enable |
| core_off_o | output | 1 | Core disable request |
| osc_off_o | output | 1 | Oscillator off request |
| scg_o | output | 2 | Clock generator control bits |

## Verification
Both read ports and the constant substitution are combinational, so a read result is due in the same cycle as its index and mode. Writes, flag updates and reset act on the next rising edge, and their effect on the read ports and control outputs is due one cycle later. The bench drives inputs on the falling edge and compares the read ports one nanosecond later, before the rising edge. Only after that edge does it apply the cycle's write, flag update or reset to its reference model. In this way every comparison sees exactly the state left by earlier edges, and the state written in the current cycle is never seen early.

// File: rtl/regfile_cg.sv
module regfile_cg #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [1:0]    rd_a_mode,
  output logic [DW-1:0] rd_a_data,
  input  logic [AW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic          wr_byte,
  input  logic [DW-1:0] wr_data,
  input  logic          flg_en,
  input  logic          flg_byte,
  input  logic [DW-1:0] flg_result,
  input  logic          flg_carry,
  output logic          gie_o,
  output logic          core_off_o,
  output logic          osc_off_o,
  output logic [1:0]    scg_o
);
  localparam logic [AW-1:0] SR_IDX = AW'(2);
  localparam logic [AW-1:0] CG_IDX = AW'(3);

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] wr_val;
  logic          sr_wr, flg_z, flg_n;

  assign wr_val = wr_byte ? {{(DW-8){1'b0}}, wr_data[7:0]} : wr_data;
  assign sr_wr  = wr_en && (wr_idx == SR_IDX);
  assign flg_z  = flg_byte ? (flg_result[7:0] == 8'd0) : (flg_result == '0);
  assign flg_n  = flg_byte ? flg_result[7] : flg_result[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (wr_en && (wr_idx != CG_IDX)) regs[wr_idx] <= wr_val;
      if (flg_en && !sr_wr) regs[SR_IDX][2:0] <= {flg_n, flg_z, flg_carry};
    end
  end

  always_comb begin
    rd_a_data = regs[rd_a_idx];
    if (rd_a_idx == CG_IDX) begin
      case (rd_a_mode)
        2'd0:    rd_a_data = '0;
        2'd1:    rd_a_data = DW'(1);
        2'd2:    rd_a_data = DW'(2);
        default: rd_a_data = '1;
      endcase
    end else if (rd_a_idx == SR_IDX) begin
      case (rd_a_mode)
        2'd0:    rd_a_data = regs[SR_IDX];
        2'd1:    rd_a_data = '0;
        2'd2:    rd_a_data = DW'(4);
        default: rd_a_data = DW'(8);
      endcase
    end
  end

  assign rd_b_data  = regs[rd_b_idx];
  assign gie_o      = regs[SR_IDX][3];
  assign core_off_o = regs[SR_IDX][4];
  assign osc_off_o  = regs[SR_IDX][5];
  assign scg_o      = regs[SR_IDX][7:6];
endmodule

// File: rtl/regfile_cg_chk.sv
module regfile_cg_chk #(
  parameter int DW   = 16,
  parameter int AW   = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] rd_a_idx,
  input logic [1:0]    rd_a_mode,
  input logic [DW-1:0] rd_a_data,
  input logic [AW-1:0] rd_b_idx,
  input logic [DW-1:0] rd_b_data,
  input logic          wr_en,
  input logic [AW-1:0] wr_idx,
  input logic          wr_byte,
  input logic [DW-1:0] wr_data,
  input logic          flg_en,
  input logic          gie_o,
  input logic          core_off_o
);
  assert_word_write_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_byte && wr_idx != AW'(2) && wr_idx != AW'(3)) ##1 (rd_b_idx == $past(wr_idx))
      |-> rd_b_data == $past(wr_data));

  assert_byte_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_byte && wr_idx != AW'(2) && wr_idx != AW'(3)) ##1 (rd_b_idx == $past(wr_idx))
      |-> rd_b_data == {{(DW-8){1'b0}}, $past(wr_data[7:0])});

  assert_cg_ones_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == AW'(3) && rd_a_mode == 2'd3) |-> rd_a_data == '1);

  assert_cg_discard_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == AW'(3)) |-> rd_b_data == '0);

  assert_abs_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == AW'(2) && rd_a_mode == 2'd1) |-> rd_a_data == '0);

  assert_flags_keep_ctl_R6: assert property (@(posedge clk) disable iff (rst)
    (flg_en && !(wr_en && wr_idx == AW'(2)))
      |=> (gie_o == $past(gie_o)) && (core_off_o == $past(core_off_o)));

  assert_sr_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == AW'(2))
      |=> (gie_o == $past(wr_data[3])) && (core_off_o == $past(wr_data[4])));

  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!gie_o && !core_off_o && rd_b_data == '0));
endmodule

bind regfile_cg regfile_cg_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_a_mode(rd_a_mode),
  .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .wr_data(wr_data),
  .flg_en(flg_en), .gie_o(gie_o), .core_off_o(core_off_o)
);

// File: tb/regfile_cg_tb.sv
`timescale 1ns/1ps
module regfile_cg_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [1:0]  rd_a_mode = '0;
  logic [15:0] rd_a_data, rd_b_data, wr_data = '0, flg_result = '0;
  logic        wr_en = 0, wr_byte = 0, flg_en = 0, flg_byte = 0, flg_carry = 0;
  logic        gie_o, core_off_o, osc_off_o;
  logic [1:0]  scg_o;

  regfile_cg u_dut (.*);

  logic [15:0] m [16];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_a(int i, logic [1:0] md);
    if (i == 3) case (md) 2'd0: return 16'h0000; 2'd1: return 16'h0001;
                          2'd2: return 16'h0002; default: return 16'hFFFF; endcase
    if (i == 2) case (md) 2'd0: return m[2]; 2'd1: return 16'h0000;
                          2'd2: return 16'h0004; default: return 16'h0008; endcase
    return m[i];
  endfunction

  task automatic model_edge();
    if (rst) begin
      for (int i = 0; i < 16; i++) m[i] = '0;
    end else begin
      logic sw = wr_en && wr_idx == 4'd2;
      if (flg_en && !sw) begin
        logic z = flg_byte ? (flg_result[7:0] == 0) : (flg_result == 0);
        logic n = flg_byte ? flg_result[7] : flg_result[15];
        m[2][2:0] = {n, z, flg_carry};
      end
      if (wr_en && wr_idx != 4'd3) m[wr_idx] = wr_byte ? {8'h00, wr_data[7:0]} : wr_data;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr_en = 0; flg_en = 0;
  endtask

  task automatic check_all();
    string ta;
    #1;
    ta = (rd_a_idx == 3) ? "R3 port A" : (rd_a_idx == 2) ? "R4 port A" : "R5 port A";
    chk(ta, rd_a_data, exp_a(rd_a_idx, rd_a_mode));
    chk("R1 port B", rd_b_data, m[rd_b_idx]);
    chk("R7 ctl outputs", {11'd0, scg_o, osc_off_o, core_off_o, gie_o}, {11'd0, m[2][7:3]});
  endtask

  task automatic wr(logic [3:0] i, logic b, logic [15:0] d);
    wr_en = 1; wr_idx = i; wr_byte = b; wr_data = d;
  endtask

  task automatic flg(logic b, logic [15:0] r, logic c);
    flg_en = 1; flg_byte = b; flg_result = r; flg_carry = c;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 16; i++) m[i] = 'x;
    @(negedge clk);
    tick(); tick();
    rst = 0;
    for (int i = 0; i < 16; i++) begin
      rd_b_idx = 4'(i); #1;
      chk("R9 reset entry", rd_b_data, 16'h0000);
    end
    chk("R9 reset ctl", {11'd0, scg_o, osc_off_o, core_off_o, gie_o}, 16'h0000);

    wr(4'd5, 0, 16'hFFFF); rd_b_idx = 4'd5; #1;
    chk("R1 read in write cycle", rd_b_data, 16'h0000);
    tick(); #1;
    chk("R1 word write", rd_b_data, 16'hFFFF);
    wr(4'd5, 1, 16'h1234); tick(); #1;
    chk("R2 byte write", rd_b_data, 16'h0034);

    wr(4'd3, 0, 16'hABCD); tick(); rd_b_idx = 4'd3; #1;
    chk("R3 write discarded", rd_b_data, 16'h0000);
    rd_a_idx = 4'd3;
    for (int md = 0; md < 4; md++) begin
      rd_a_mode = 2'(md); #1;
      chk("R3 constant", rd_a_data, exp_a(3, 2'(md)));
    end

    wr(4'd2, 0, 16'h00F8); tick();
    rd_a_idx = 4'd2; rd_a_mode = 2'd0; #1;
    chk("R4 status read", rd_a_data, 16'h00F8);
    chk("R7 outputs", {11'd0, scg_o, osc_off_o, core_off_o, gie_o}, 16'h001F);
    rd_a_mode = 2'd2; #1; chk("R4 const 4", rd_a_data, 16'h0004);
    rd_a_mode = 2'd3; #1; chk("R4 const 8", rd_a_data, 16'h0008);

    rd_a_mode = 2'd0;
    flg(0, 16'h0000, 1); tick(); #1;
    chk("R6 word zero carry", rd_a_data, 16'h00FB);
    flg(1, 16'h0180, 0); tick(); #1;
    chk("R6 byte negative", rd_a_data, 16'h00FC);
    flg(1, 16'h0100, 0); tick(); #1;
    chk("R6 byte zero", rd_a_data, 16'h00FA);
    flg(0, 16'h8000, 1); tick(); #1;
    chk("R6 word negative", rd_a_data, 16'h00FD);

    wr(4'd2, 0, 16'h0008); flg(0, 16'h0000, 1); tick(); #1;
    chk("R8 write beats flags", rd_a_data, 16'h0008);

    wr(4'd7, 0, 16'h5A5A); tick();
    rd_a_idx = 4'd7;
    for (int md = 0; md < 4; md++) begin
      rd_a_mode = 2'(md); #1;
      chk("R5 mode ignored", rd_a_data, 16'h5A5A);
    end

    for (int it = 0; it < 3000; it++) begin
      rd_a_idx = 4'($urandom); rd_a_mode = 2'($urandom); rd_b_idx = 4'($urandom);
      wr_en = ($urandom % 3) != 0; wr_idx = 4'($urandom); wr_byte = 1'($urandom);
      wr_data = 16'($urandom);
      flg_en = ($urandom % 3) == 0; flg_byte = 1'($urandom); flg_carry = 1'($urandom);
      case ($urandom % 4)
        0: flg_result = 16'h0000;
        1: flg_result = {8'($urandom), 8'h00};
        default: flg_result = 16'($urandom);
      endcase
      check_all();
      tick();
    end

    rst = 1; tick(); rst = 0;
    for (int i = 0; i < 16; i++) begin
      rd_b_idx = 4'(i); #1;
      chk("R9 reset after traffic", rd_b_data, 16'h0000);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule